// File: doc/BRIEF.md
# Class-Tagged Frame Steering Router

The router sits behind an upstream packet classifier. It takes in one pipelined word stream. Each frame on that stream comes with a 3-bit class tag on a sideband input, and the tag is valid on the first word of the frame. The router sends the whole frame to one of three consumer streams:

- port 0, the host network-interface path;
- port 1, the remote-configuration path;
- port 2, the embedded-processor path.

The class-to-port assignment is fixed by parameters. A class with no assignment goes to the host path, so no frame is ever discarded.

The destination is chosen from the tag on the first word of a frame. That choice is then held until the word flagged as last has been handed over. The input ready follows the ready of the chosen consumer only. The other consumers see valid held low. Data, last flag and valid pass through with no register stage, so a word appears at its consumer in the same cycle it is offered.

Top module: `classRouter`

## Requirements
- R1: After reset, with no input word offered, every output valid bit is low.
- R2: A frame whose tag on its first word is 7 is delivered on port 0 (outValid bit 0).
- R3: A frame whose tag on its first word is 5 is delivered on port 1 (outValid bit 1).
- R4: A frame whose tag on its first word is 0 is delivered on port 2 (outValid bit 2).
- R5: A frame whose first-word tag is 1, 2, 3, 4 or 6 is delivered on port 0.
- R6: Once the first word of a frame has been accepted without its last flag, every later word of that frame goes to the same port until a word with the last flag is accepted. Tag changes and idle cycles inside the frame have no effect on the port.
- R7: inReady equals the outReady bit of the selected port; the ready bits of unselected ports have no effect on it.
- R8: At most one outValid bit is high, and only while inValid is high.
- R9: The selected port carries inData and inLast in the same cycle as they are presented (zero latency; outData holds port p in bits p*DATA_W upward).
- R10: No word is dropped: every accepted input word is accepted on exactly one output, and the counts are equal.
- R11: A single-word frame (last flag on its first word) leaves no routing state behind, so the next word takes its port from its own tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input word valid |
| inReady | output | 1 | Input word accepted when high with inValid |
| inData | input | DATA_W | Input word |
| inLast | input | 1 | Marks the last word of a frame |
| inClass | input | CLASS_W | Classifier tag, sampled on the first word of a frame |
| outValid | output | 3 | Per-port valid, bit p for port p |
| outReady | input | 3 | Per-port ready from the consumers |
| outData | output | 3*DATA_W | Per-port data, port p in slice p |
| outLast | output | 3 | Per-port last flag |

## Verification
Multi-word frames are sent with each assigned tag, and single-word frames with every unassigned tag. Together these show whether the decode sends each tag to the right port and whether unassigned tags fall through to the host path.

Some frames change their tag after the first word or pause mid-frame. These separate a port latched per frame from one decoded per word. Stalls with only the selected consumer not ready, and with only an unselected one not ready, show whether ready is taken from the right port.

A single-word frame followed by a frame with a different tag shows whether the end-of-frame handling releases the latched port.

// File: rtl/classRouterPkg.sv
package classRouterPkg;
  localparam int NUM_PORTS = 3;
  localparam int PORT_NIC  = 0;
  localparam int PORT_CFG  = 1;
  localparam int PORT_CPU  = 2;

  // strobes from control to datapath
  typedef struct packed {
    logic [NUM_PORTS-1:0] portHot;
  } routeCtrl_t;
endpackage

// File: rtl/routerCtrl.sv
module routerCtrl
  import classRouterPkg::*;
#(
  parameter int CLASS_W = 3,
  parameter logic [CLASS_W-1:0] NIC_CLASS = 7,
  parameter logic [CLASS_W-1:0] CFG_CLASS = 5,
  parameter logic [CLASS_W-1:0] CPU_CLASS = 0
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [CLASS_W-1:0] inClass,
  input  logic               beatDone,
  input  logic               beatLast,
  output routeCtrl_t         ctrl
);
  logic                 inFrame;
  logic [NUM_PORTS-1:0] heldHot;
  logic [NUM_PORTS-1:0] newHot;

  // tag decode; NIC class and all unassigned classes go to the host port
  always_comb begin
    newHot = '0;
    if (inClass == CFG_CLASS)      newHot[PORT_CFG] = 1'b1;
    else if (inClass == CPU_CLASS) newHot[PORT_CPU] = 1'b1;
    else                           newHot[PORT_NIC] = 1'b1;
  end

  assign ctrl.portHot = inFrame ? heldHot : newHot;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inFrame <= 1'b0;
      heldHot <= '0;
    end else if (beatDone) begin
      inFrame <= !beatLast;
      if (!inFrame) heldHot <= newHot;
    end
  end
endmodule

// File: rtl/routerData.sv
module routerData
  import classRouterPkg::*;
#(
  parameter int DATA_W = 16
) (
  input  routeCtrl_t                  ctrl,
  input  logic                        inValid,
  output logic                        inReady,
  input  logic [DATA_W-1:0]           inData,
  input  logic                        inLast,
  output logic [NUM_PORTS-1:0]        outValid,
  input  logic [NUM_PORTS-1:0]        outReady,
  output logic [NUM_PORTS*DATA_W-1:0] outData,
  output logic [NUM_PORTS-1:0]        outLast,
  output logic                        beatDone,
  output logic                        beatLast
);
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    assign outValid[p]                  = inValid & ctrl.portHot[p];
    assign outLast[p]                   = inLast & ctrl.portHot[p];
    assign outData[p*DATA_W +: DATA_W]  = inData;
  end

  assign inReady  = |(ctrl.portHot & outReady);
  assign beatDone = inValid & inReady;
  assign beatLast = inLast;
endmodule

// File: rtl/classRouter.sv
module classRouter
  import classRouterPkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int CLASS_W = 3,
  parameter logic [CLASS_W-1:0] NIC_CLASS = 7,
  parameter logic [CLASS_W-1:0] CFG_CLASS = 5,
  parameter logic [CLASS_W-1:0] CPU_CLASS = 0
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     inValid,
  output logic                     inReady,
  input  logic [DATA_W-1:0]        inData,
  input  logic                     inLast,
  input  logic [CLASS_W-1:0]       inClass,
  output logic [2:0]               outValid,
  input  logic [2:0]               outReady,
  output logic [3*DATA_W-1:0]      outData,
  output logic [2:0]               outLast
);
  routeCtrl_t ctrl;
  logic beatDone;
  logic beatLast;

  routerCtrl #(
    .CLASS_W(CLASS_W), .NIC_CLASS(NIC_CLASS),
    .CFG_CLASS(CFG_CLASS), .CPU_CLASS(CPU_CLASS)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .inClass(inClass),
    .beatDone(beatDone), .beatLast(beatLast), .ctrl(ctrl)
  );

  routerData #(.DATA_W(DATA_W)) i_data (
    .ctrl(ctrl), .inValid(inValid), .inReady(inReady),
    .inData(inData), .inLast(inLast),
    .outValid(outValid), .outReady(outReady),
    .outData(outData), .outLast(outLast),
    .beatDone(beatDone), .beatLast(beatLast)
  );
endmodule

// File: rtl/classRouterChk.sv
module classRouterChk #(
  parameter int DATA_W = 16
) (
  input logic                clk,
  input logic                rstN,
  input logic                inValid,
  input logic                inReady,
  input logic [DATA_W-1:0]   inData,
  input logic                inLast,
  input logic [2:0]          outValid,
  input logic [2:0]          outReady,
  input logic [3*DATA_W-1:0] outData,
  input logic [2:0]          outLast
);
  // R8
  one_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(outValid));

  // R10
  no_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|outValid) == inValid);

  // R7
  ready_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid |-> (inReady == |(outValid & outReady)));

  // R6
  hold_port_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady && !inLast) |=> (!inValid || outValid == $past(outValid)));

  for (genvar p = 0; p < 3; p++) begin : g_pass
    // R9
    data_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
      outValid[p] |-> (outData[p*DATA_W +: DATA_W] == inData && outLast[p] == inLast));
  end
endmodule

bind classRouter classRouterChk #(.DATA_W(DATA_W)) u_classRouterChk (.*);

// File: tb/test_classRouter.sv
`timescale 1ns/1ps
module test_classRouter;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          inValid = 1'b0;
  logic          inReady;
  logic [DW-1:0] inData = '0;
  logic          inLast = 1'b0;
  logic [2:0]    inClass = '0;
  logic [2:0]    outValid;
  logic [2:0]    outReady = '0;
  logic [3*DW-1:0] outData;
  logic [2:0]    outLast;

  int checks = 0;
  int fails = 0;
  int expAcc = 0;
  int inCnt = 0;
  int outCnt = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  classRouter #(.DATA_W(DW)) i_classRouter (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inData(inData), .inLast(inLast), .inClass(inClass),
    .outValid(outValid), .outReady(outReady),
    .outData(outData), .outLast(outLast)
  );

  always @(posedge clk) if (rstN) begin
    if (inValid && inReady) inCnt++;
    if (|(outValid & outReady)) outCnt++;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // present one word, check outputs before the next edge
  task automatic beat(input logic [2:0] cls, input logic [DW-1:0] d, input logic lst,
                      input logic [2:0] rdy, input int expPort, input string req);
    logic [2:0] expV;
    @(negedge clk);
    inValid = 1'b1; inClass = cls; inData = d; inLast = lst; outReady = rdy;
    #1;
    expV = 3'b001 << expPort;
    chk(outValid == expV, {req, " port"}, outValid, expV);
    chk(inReady == rdy[expPort], {req, " R7 ready"}, inReady, rdy[expPort]);
    chk(outData[expPort*DW +: DW] == d, {req, " R9 data"}, outData[expPort*DW +: DW], d);
    chk(outLast[expPort] == lst, {req, " R9 last"}, outLast[expPort], lst);
    if (rdy[expPort]) expAcc++;
  endtask

  task automatic idle();
    @(negedge clk);
    inValid = 1'b0;
    #1;
    chk(outValid == 3'b000, "R8 idle valid", outValid, 0);
  endtask

  task automatic testReset();
    #1;
    chk(outValid == 3'b000, "R1 reset valid", outValid, 0);
  endtask

  task automatic testFrame(input logic [2:0] cls, input int port, input string req);
    for (int i = 0; i < 3; i++)
      beat(cls, DW'(16'h100 * (port + 1) + i), i == 2, 3'b111, port, req);
  endtask

  task automatic testUnassigned();
    logic [2:0] tags [5] = '{3'd1, 3'd2, 3'd3, 3'd4, 3'd6};
    for (int k = 0; k < 5; k++)
      beat(tags[k], DW'(16'h500 + k), 1'b1, 3'b111, 0, "R5 unassigned");
  endtask

  task automatic testMidChange();
    beat(3'd5, 16'hA000, 1'b0, 3'b111, 1, "R6 first");
    beat(3'd0, 16'hA001, 1'b0, 3'b111, 1, "R6 tag change");
    idle();
    beat(3'd7, 16'hA002, 1'b0, 3'b111, 1, "R6 after gap");
    beat(3'd0, 16'hA003, 1'b1, 3'b111, 1, "R6 last");
  endtask

  task automatic testBackpressure();
    beat(3'd0, 16'hB000, 1'b0, 3'b011, 2, "R7 selected stalled");
    beat(3'd0, 16'hB000, 1'b0, 3'b011, 2, "R7 still stalled");
    beat(3'd0, 16'hB000, 1'b0, 3'b100, 2, "R7 others not ready");
    beat(3'd5, 16'hB001, 1'b1, 3'b110, 2, "R7 last held");
  endtask

  task automatic testSingleThenNew();
    beat(3'd5, 16'hC000, 1'b1, 3'b111, 1, "R11 single word");
    beat(3'd0, 16'hC001, 1'b1, 3'b111, 2, "R11 next frame");
    idle();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    testReset();
    @(negedge clk) rstN = 1'b1;
    testReset();
    testFrame(3'd7, 0, "R2 class7");
    testFrame(3'd5, 1, "R3 class5");
    testFrame(3'd0, 2, "R4 class0");
    testUnassigned();
    testMidChange();
    testBackpressure();
    testSingleThenNew();
    @(negedge clk);
    chk(inCnt == outCnt && inCnt == expAcc, "R10 word count", inCnt, expAcc);
    chk(outCnt == expAcc, "R10 out count", outCnt, expAcc);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule